// File: doc/BRIEF.md
# AMI line transmit pulse encoder

This block turns a transmit bit stream at the line rate into return-to-zero bipolar alternate mark inversion symbols. It then plays each symbol out as a timed run of signed amplitude codes for a high-speed D/A converter. A mode pin selects the input format. In unipolar mode, one data input is encoded and the block alternates mark polarity itself. In rail-pair mode, separate positive and negative inputs state the polarity directly.

Everything runs on the fast oversampling clock. A one-cycle enable marks each bit boundary, so the output never depends on the duty cycle of a slow line clock. Each bit period holds a fixed number of fast ticks. Within each period a mark passes through four amplitude phases: overshoot, main pulse, backswing and tail. It then returns to zero. A 3-bit equalizer select picks one of five shape tables, and each table is tuned for a longer stretch of cable than the one before it.

Top module: `ami_tx_shaper`

## Requirements
- R1: A synchronous active-high reset drives `dac_code` to 0 and `rail_err` to 0, and sets the alternation state so that the first unipolar mark after reset is positive.
- R2: Data, mode and `eq_sel` are sampled only on a clock edge where `bit_en` is high. Changing them between enables has no effect. Tick t (0..15) of the sampled bit appears on `dac_code` after the (t+1)-th rising edge following the sampling edge.
- R3: Within a bit, ticks 0-1 carry the overshoot level, ticks 2-7 the main level, ticks 8-9 the backswing level, ticks 10-11 the tail level, and ticks 12-15 code 0. If no new enable arrives, the code stays 0 after tick 15.
- R4: For shape index e in 0..4, the positive levels are: overshoot 96+6e, main 90, backswing -(16+4e), tail -(4+2e). They are written as 8-bit two's complement.
- R5: `eq_sel` values 0..4 select shape index e equal to `eq_sel`. Values 5, 6 and 7 select shape index 0.
- R6: With `dual_rail`=0, a 1 on `uni_data` yields a mark whose polarity is opposite to the previous mark. A 0 yields code 0 in every tick and leaves the polarity state unchanged.
- R7: A negative mark outputs the two's-complement negation of the positive level, tick for tick.
- R8: With `dual_rail`=1, `pos_data`=1 yields a positive mark and `neg_data`=1 yields a negative mark. `uni_data` is ignored. The alternation state is held, so a return to unipolar mode continues the polarity sequence.
- R9: With `dual_rail`=1 and both rails at 1, the bit outputs code 0 in every tick. `rail_err` is high for exactly the 16 output cycles of that bit and low for every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse at each bit boundary |
| dual_rail | input | 1 | 0: unipolar input, 1: positive/negative rail pair |
| uni_data | input | 1 | Unipolar data bit |
| pos_data | input | 1 | Positive-rail data bit |
| neg_data | input | 1 | Negative-rail data bit |
| eq_sel | input | 3 | Equalizer (cable length) select |
| dac_code | output | CODE_W (8) | Signed amplitude code, one per fast tick |
| rail_err | output | 1 | High during a bit where both rails were 1 |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and 8-bit codes. This keeps the largest overshoot, 120, and its negation inside the code range, and every tick of every phase boundary can be checked against a table written from R3 and R4. The bench drives bit periods of exactly 16 cycles to check seamless back-to-back pulses. It also drives longer periods to reach the idle tail after tick 15. Between enables it scrambles the inputs to show they are ignored.

// File: rtl/ami_pkg.sv
package ami_pkg;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_POS   = 2'd1,
        SYM_NEG   = 2'd2
    } sym_kind_e;

    typedef enum logic [2:0] {
        PH_OVER = 3'd0,
        PH_MAIN = 3'd1,
        PH_BACK = 3'd2,
        PH_TAIL = 3'd3,
        PH_NULL = 3'd4
    } phase_e;

    typedef struct packed {
        sym_kind_e  kind;
        logic       err;
        logic [2:0] eq;
    } sym_t;

    localparam int NUM_SHAPES = 5;
    localparam int NUM_PHASES = 4;

    // Phase boundaries scale with the tick count of one bit period.
    function automatic phase_e phase_of(input int tick, input int ticks);
        if (tick < ticks / 8)          return PH_OVER;
        if (tick < ticks / 2)          return PH_MAIN;
        if (tick < (ticks * 5) / 8)    return PH_BACK;
        if (tick < (ticks * 3) / 4)    return PH_TAIL;
        return PH_NULL;
    endfunction

    // Positive-polarity level for one shape and phase.
    function automatic int shape_level(input int shape, input int phase);
        case (phase)
            0:       return 96 + 6 * shape;
            1:       return 90;
            2:       return -(16 + 4 * shape);
            3:       return -(4 + 2 * shape);
            default: return 0;
        endcase
    endfunction

    // Undefined equalizer codes fall back to the shortest-cable shape.
    function automatic logic [2:0] shape_index(input logic [2:0] eq);
        return (int'(eq) < NUM_SHAPES) ? eq : 3'd0;
    endfunction

endpackage

// File: rtl/ami_symbol_encoder.sv
module ami_symbol_encoder
    import ami_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       dual_rail,
    input  logic       uni_data,
    input  logic       pos_data,
    input  logic       neg_data,
    input  logic [2:0] eq_sel,
    output sym_t       sym_q
);

    logic next_pos_q;
    sym_t sym_d;

    always_comb begin
        sym_d.kind = SYM_SPACE;
        sym_d.err  = 1'b0;
        sym_d.eq   = shape_index(eq_sel);
        if (dual_rail) begin
            if (pos_data && neg_data) begin
                sym_d.err = 1'b1;
            end else if (pos_data) begin
                sym_d.kind = SYM_POS;
            end else if (neg_data) begin
                sym_d.kind = SYM_NEG;
            end
        end else if (uni_data) begin
            sym_d.kind = next_pos_q ? SYM_POS : SYM_NEG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q.kind <= SYM_SPACE;
            sym_q.err  <= 1'b0;
            sym_q.eq   <= 3'd0;
            next_pos_q <= 1'b1;
        end else if (bit_en) begin
            sym_q <= sym_d;
            if (!dual_rail && uni_data) begin
                next_pos_q <= !next_pos_q;
            end
        end
    end

endmodule

// File: rtl/ami_tick_timer.sv
module ami_tick_timer #(
    parameter int TICKS_PER_BIT = 16,
    parameter int TICK_W        = $clog2(TICKS_PER_BIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    output logic [TICK_W-1:0] tick_q
);

    localparam logic [TICK_W-1:0] IDLE = TICK_W'(TICKS_PER_BIT);

    // Counts ticks within a bit; parks at IDLE until the next enable.
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= IDLE;
        end else if (bit_en) begin
            tick_q <= '0;
        end else if (tick_q != IDLE) begin
            tick_q <= tick_q + 1'b1;
        end
    end

endmodule

// File: rtl/ami_pulse_shaper.sv
module ami_pulse_shaper
    import ami_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int TICK_W        = $clog2(TICKS_PER_BIT + 1),
    parameter int CODE_W        = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  sym_t                     sym,
    input  logic [TICK_W-1:0]        tick,
    output logic signed [CODE_W-1:0] code_q,
    output logic                     err_q
);

    logic signed [CODE_W-1:0] tbl [NUM_SHAPES][NUM_PHASES];

    for (genvar s = 0; s < NUM_SHAPES; s++) begin : g_shape
        for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
            localparam int LEVEL = shape_level(s, p);
            assign tbl[s][p] = LEVEL[CODE_W-1:0];
        end
    end

    phase_e                   ph;
    logic                     active;
    logic signed [CODE_W-1:0] mag;
    logic signed [CODE_W-1:0] code_d;

    always_comb begin
        ph     = phase_of(int'(tick), TICKS_PER_BIT);
        active = (ph != PH_NULL);
        mag    = active ? tbl[sym.eq][ph[1:0]] : '0;
        case (sym.kind)
            SYM_POS: code_d = mag;
            SYM_NEG: code_d = -mag;
            default: code_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            err_q  <= 1'b0;
        end else begin
            code_q <= code_d;
            err_q  <= sym.err && (int'(tick) < TICKS_PER_BIT);
        end
    end

endmodule

// File: rtl/ami_tx_shaper.sv
module ami_tx_shaper
    import ami_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int CODE_W        = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bit_en,
    input  logic                     dual_rail,
    input  logic                     uni_data,
    input  logic                     pos_data,
    input  logic                     neg_data,
    input  logic [2:0]               eq_sel,
    output logic signed [CODE_W-1:0] dac_code,
    output logic                     rail_err
);

    localparam int TICK_W = $clog2(TICKS_PER_BIT + 1);

    sym_t              sym_w;
    logic [TICK_W-1:0] tick_w;

    ami_symbol_encoder u_enc (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .dual_rail (dual_rail),
        .uni_data  (uni_data),
        .pos_data  (pos_data),
        .neg_data  (neg_data),
        .eq_sel    (eq_sel),
        .sym_q     (sym_w)
    );

    ami_tick_timer #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .TICK_W        (TICK_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .tick_q (tick_w)
    );

    ami_pulse_shaper #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .TICK_W        (TICK_W),
        .CODE_W        (CODE_W)
    ) u_shaper (
        .clk    (clk),
        .rst    (rst),
        .sym    (sym_w),
        .tick   (tick_w),
        .code_q (dac_code),
        .err_q  (rail_err)
    );

endmodule

// File: rtl/ami_tx_shaper_chk.sv
module ami_tx_shaper_chk
    import ami_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int CODE_W        = 8,
    parameter int TICK_W        = $clog2(TICKS_PER_BIT + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bit_en,
    input logic                     dual_rail,
    input logic                     uni_data,
    input logic                     pos_data,
    input logic                     neg_data,
    input logic signed [CODE_W-1:0] dac_code,
    input logic                     rail_err,
    input sym_t                     sym_w,
    input logic [TICK_W-1:0]        tick_w
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dac_code == '0 && !rail_err));

    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> (tick_w == '0));

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(tick_w) == TICKS_PER_BIT) |=> (dac_code == '0 && !rail_err));

    p_space_null_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !dual_rail && !uni_data) |=> (sym_w.kind == SYM_SPACE));

    p_single_no_err_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !dual_rail) |=> !sym_w.err);

    p_dual_pos_r8: assert property (@(posedge clk) disable iff (rst)
        (bit_en && dual_rail && pos_data && !neg_data) |=> (sym_w.kind == SYM_POS));

    p_dual_neg_r8: assert property (@(posedge clk) disable iff (rst)
        (bit_en && dual_rail && neg_data && !pos_data) |=> (sym_w.kind == SYM_NEG));

    p_err_null_r9: assert property (@(posedge clk) disable iff (rst)
        rail_err |-> (dac_code == '0));

endmodule

bind ami_tx_shaper ami_tx_shaper_chk #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .CODE_W        (CODE_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .dual_rail (dual_rail),
    .uni_data  (uni_data),
    .pos_data  (pos_data),
    .neg_data  (neg_data),
    .dac_code  (dac_code),
    .rail_err  (rail_err),
    .sym_w     (sym_w),
    .tick_w    (tick_w)
);

// File: tb/ami_tx_shaper_tb_top.sv
`timescale 1ns/1ps
module ami_tx_shaper_tb_top;

    localparam int TPB = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst = 1'b1;
    logic              bit_en = 1'b0;
    logic              dual_rail = 1'b0;
    logic              uni_data = 1'b0;
    logic              pos_data = 1'b0;
    logic              neg_data = 1'b0;
    logic [2:0]        eq_sel = 3'd0;
    logic signed [7:0] dac_code;
    logic              rail_err;

    ami_tx_shaper dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .dual_rail (dual_rail),
        .uni_data  (uni_data),
        .pos_data  (pos_data),
        .neg_data  (neg_data),
        .eq_sel    (eq_sel),
        .dac_code  (dac_code),
        .rail_err  (rail_err)
    );

    typedef struct {
        int    kind;   // 0 space, 1 positive, -1 negative
        int    shape;
        bit    err;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int  checks = 0;
    int  fails  = 0;
    bit  next_pos = 1'b1;
    bit  done = 1'b0;

    // Levels written from R3/R4/R7.
    function automatic int exp_level(input int kind, input int shape, input int t);
        int pos;
        if (t < 2)        pos = 96 + 6 * shape;
        else if (t < 8)   pos = 90;
        else if (t < 10)  pos = -(16 + 4 * shape);
        else if (t < 12)  pos = -(4 + 2 * shape);
        else              pos = 0;
        return kind * pos;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one bit period of 'gap' cycles; scrambles inputs after sampling.
    task automatic send_bit(input bit dual, input bit u, input bit p, input bit n,
                            input logic [2:0] eq, input int gap, input string tag);
        exp_item_t it;
        @(negedge clk);
        dual_rail = dual; uni_data = u; pos_data = p; neg_data = n; eq_sel = eq;
        bit_en = 1'b1;
        it.kind = 0; it.err = 1'b0; it.tag = tag;
        it.shape = (eq < 3'd5) ? int'(eq) : 0;
        if (!dual) begin
            if (u) begin
                it.kind = next_pos ? 1 : -1;
                next_pos = !next_pos;
            end
        end else if (p && n) begin
            it.err = 1'b1;
        end else if (p) begin
            it.kind = 1;
        end else if (n) begin
            it.kind = -1;
        end
        exp_q.push_back(it);
        @(negedge clk);
        bit_en = 1'b0;
        // R2: changes between enables must have no effect.
        uni_data = ~u; pos_data = ~p; neg_data = ~n; eq_sel = eq + 3'd3;
        repeat (gap - 2) @(negedge clk);
    endtask

    // Monitor: tracks bit boundaries and checks every cycle after each edge.
    initial begin
        exp_item_t cur;
        int        mtick;
        bit        en;
        cur.kind = 0; cur.shape = 0; cur.err = 1'b0; cur.tag = "R1";
        mtick = TPB;
        wait (!rst);
        forever begin
            @(posedge clk);
            en = bit_en;
            #1;
            if (!done) begin
                if (mtick < TPB) begin
                    check({cur.tag, " code"}, int'(dac_code), exp_level(cur.kind, cur.shape, mtick));
                    check({cur.err ? "R9" : cur.tag, " err"}, int'(rail_err), int'(cur.err));
                end else begin
                    check("R3 idle code", int'(dac_code), 0);
                    check("R9 idle err", int'(rail_err), 0);
                end
            end
            if (en) begin
                if (exp_q.size() > 0) cur = exp_q.pop_front();
                mtick = 0;
            end else if (mtick < TPB) begin
                mtick++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset code", int'(dac_code), 0);
        check("R1 reset err", int'(rail_err), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 quiet after reset", int'(dac_code), 0);

        // Unipolar: first mark positive, then alternation and spaces.
        send_bit(0, 1, 0, 0, 3'd0, TPB, "R1");
        send_bit(0, 1, 0, 0, 3'd0, TPB, "R7");
        send_bit(0, 0, 0, 0, 3'd0, TPB, "R6");
        send_bit(0, 1, 0, 0, 3'd0, TPB, "R6");
        send_bit(0, 0, 1, 1, 3'd0, TPB, "R6");
        send_bit(0, 1, 0, 0, 3'd0, TPB, "R6");
        // Shape sweep, positive and negative marks.
        for (int e = 1; e < 5; e++) begin
            send_bit(0, 1, 0, 0, 3'(e), TPB, "R4");
            send_bit(0, 1, 0, 0, 3'(e), TPB, "R4");
        end
        for (int e = 5; e < 8; e++) begin
            send_bit(0, 1, 0, 0, 3'(e), TPB, "R5");
        end
        // Longer periods reach the idle state after tick 15.
        send_bit(0, 1, 0, 0, 3'd2, TPB + 8, "R3");
        send_bit(0, 1, 0, 0, 3'd4, TPB + 3, "R2");
        // Rail pair mode.
        send_bit(1, 1, 1, 0, 3'd1, TPB, "R8");
        send_bit(1, 0, 1, 0, 3'd1, TPB, "R8");
        send_bit(1, 1, 0, 1, 3'd3, TPB, "R8");
        send_bit(1, 0, 1, 1, 3'd2, TPB, "R9");
        send_bit(1, 1, 0, 0, 3'd2, TPB, "R8");
        send_bit(1, 0, 1, 1, 3'd0, TPB + 5, "R9");
        // Back to unipolar: polarity sequence continues.
        send_bit(0, 1, 0, 0, 3'd0, TPB, "R8");
        send_bit(0, 1, 0, 0, 3'd0, TPB, "R6");
        repeat (TPB + 4) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule